// File: doc/BRIEF.md
# Low-Frequency Tick Timer with Bus-Side Registers

This block is a system tick timer built from two clock domains. A small register file sits on a fast bus clock and holds a control word, a reload value and a status flag. The counting logic runs from a slow 32768 Hz clock. Software programs the reload value and then raises the start bit while the enable bit is set. The slow domain responds to that rising edge by copying the reload value into a 28-bit down-counter. It then steps the counter once per slow tick. On the tick that would take the count to zero, the counter instead reloads and signals an expiry.

Each expiry sets a sticky status flag, and that flag drives a level interrupt line. Control bits cross into the slow domain through synchronizer chains. The running count travels back to the bus as a snapshot that a toggle qualifies, so a read never returns a half-updated value. From the start write until the freshly loaded count has arrived on the bus side, the count register reads zero. A debug-halt input can freeze the count when the halt-enable bit allows it.

Top module: `slow_tick_timer`

## Requirements
- R1: After reset every register reads zero, the count reads zero and `irq` is low.
- R2: Register map on `reg_addr`. 0 is control: bit 0 enable, bit 1 start, bit 2 halt-enable. 1 is the reload value, masked to 28 bits, with bits 31:28 reading zero. 2 is the count, read-only, and writes to it are ignored. 3 is status: bit 0 is the expiry flag, cleared by writing one.
- R3: When the enable AND start pair goes from 0 to 1, the counter loads the reload value on the third rising `slow_clk` edge after the write.
- R4: While running, the count drops by one per slow tick. A tick at count 1 (or 0) reloads the reload value and is the expiry, so a reload value P gives a period of P ticks.
- R5: Writing the reload value while running does not change the current count. The new value is used at the next reload.
- R6: From the start write until the loaded count is visible on the bus side, the count reads zero while control reads back with start set.
- R7: An expiry sets the status flag, and `irq` follows the flag. Writing one to status bit 0 clears it. If an expiry and the clear fall in the same cycle, the expiry wins.
- R8: Writing control with enable 0, which includes an all-zero write, stops the timer and clears the status flag in the next bus cycle. While enable is 0 the count is forced to zero.
- R9: With halt-enable set and `dbg_halt` high, the count holds its value. With halt-enable clear, `dbg_halt` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Fast register-bus clock |
| slow_clk | input | 1 | 32768 Hz counting clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| reg_addr | input | 2 | Register select |
| reg_we | input | 1 | Write strobe, one bus cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| dbg_halt | input | 1 | Debug-halt request, asynchronous |
| irq | output | 1 | Level interrupt, high while the status flag is set |

## Verification
A control write reaches the counter on the third slow edge after the bus edge that stores it. A counter change then appears in the count register and the status flag about three bus edges after its slow edge. Status clears from a write-one or a disable show on the very next bus cycle. The bench issues every start write a few bus cycles after a slow edge, so the load edge is known exactly. It then counts slow edges and waits five bus cycles before sampling at a falling bus edge. That places each sample inside a window where the expected count is fixed by the tick arithmetic alone.

// File: rtl/tt_pkg.sv
package tt_pkg;

  typedef enum logic [1:0] {
    A_CTRL    = 2'd0,
    A_RELOAD  = 2'd1,
    A_COUNT   = 2'd2,
    A_STATUS  = 2'd3
  } tt_addr_e;

  localparam int B_EN    = 0;
  localparam int B_START = 1;
  localparam int B_HALT  = 2;
  localparam int CTRL_W  = 3;

  typedef struct packed {
    logic halt_en;
    logic run;
    logic en;
  } tt_ctl_t;

endpackage

// File: rtl/tt_sync.sv
module tt_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/tt_slow_core.sv
module tt_slow_core #(
  parameter int CW = 28
) (
  input  logic            clk,
  input  logic            rst_n,
  input  tt_pkg::tt_ctl_t ctl_s,
  input  logic            halt_s,
  input  logic [CW-1:0]   reload,
  output logic [CW-1:0]   count,
  output logic            load_tgl,
  output logic            exp_tgl,
  output logic            pub_tgl
);

  logic run_q;
  logic running;
  logic start_edge;
  logic stall;
  logic expire;

  function automatic logic f_terminal(input logic [CW-1:0] c);
    return c <= CW'(1);
  endfunction

  function automatic logic [CW-1:0] f_step(input logic [CW-1:0] c,
                                           input logic [CW-1:0] pl);
    return f_terminal(c) ? pl : c - 1'b1;
  endfunction

  assign running    = ctl_s.en && ctl_s.run;
  assign start_edge = running && !run_q;
  assign stall      = ctl_s.halt_en && halt_s;
  assign expire     = running && !start_edge && !stall && f_terminal(count);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= '0;
      load_tgl <= 1'b0;
      exp_tgl  <= 1'b0;
      pub_tgl  <= 1'b0;
      run_q    <= 1'b0;
    end else begin
      pub_tgl <= ~pub_tgl;
      run_q   <= running;
      if (!ctl_s.en) begin
        count <= '0;
      end else if (start_edge) begin
        count    <= reload;
        load_tgl <= ~load_tgl;
      end else if (running && !stall) begin
        count <= f_step(count, reload);
        if (expire) exp_tgl <= ~exp_tgl;
      end
    end
  end

  p_disable_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_s.en |=> (count == '0));

  p_step_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (running && run_q && !stall && count > CW'(1)) |=> (count == $past(count) - 1'b1));

  p_halt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (running && run_q && stall) |=> $stable(count));

endmodule

// File: rtl/tt_bus_regs.sv
module tt_bus_regs #(
  parameter int CW = 28,
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      addr,
  input  logic            we,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  output tt_pkg::tt_ctl_t ctl_o,
  output logic [CW-1:0]   reload_o,
  input  logic            pub_s,
  input  logic [CW-1:0]   snap_count,
  input  logic            snap_load,
  input  logic            snap_exp,
  output logic            irq
);
  import tt_pkg::*;

  logic [CTRL_W-1:0] ctrl_q;
  logic [CW-1:0]     reload_q;
  logic              status_q;
  logic              pub_q;
  logic [CW-1:0]     cap_count;
  logic              cap_load;
  logic              cap_exp;
  logic              load_pend;

  logic wr_ctrl, wr_reload, wr_stat;
  logic new_snap, exp_evt, load_done, run_rise;
  logic unused_wdata_hi;

  function automatic logic f_run(input logic [CTRL_W-1:0] c);
    return c[B_EN] & c[B_START];
  endfunction

  assign wr_ctrl   = we && (addr == A_CTRL);
  assign wr_reload = we && (addr == A_RELOAD);
  assign wr_stat   = we && (addr == A_STATUS);
  assign new_snap  = pub_s ^ pub_q;
  assign exp_evt   = new_snap && (snap_exp != cap_exp);
  assign load_done = new_snap && (snap_load != cap_load);
  assign run_rise  = wr_ctrl && f_run(wdata[CTRL_W-1:0]) && !f_run(ctrl_q);
  assign unused_wdata_hi = ^wdata[DW-1:CW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      reload_q  <= '0;
      status_q  <= 1'b0;
      pub_q     <= 1'b0;
      cap_count <= '0;
      cap_load  <= 1'b0;
      cap_exp   <= 1'b0;
      load_pend <= 1'b0;
    end else begin
      pub_q <= pub_s;
      if (new_snap) begin
        cap_count <= snap_count;
        cap_load  <= snap_load;
        cap_exp   <= snap_exp;
      end
      if (wr_ctrl)   ctrl_q   <= wdata[CTRL_W-1:0];
      if (wr_reload) reload_q <= wdata[CW-1:0];

      if (!ctrl_q[B_EN] || (wr_ctrl && !wdata[B_EN])) status_q <= 1'b0;
      else if (exp_evt)                              status_q <= 1'b1;
      else if (wr_stat && wdata[0])                  status_q <= 1'b0;

      if (wr_ctrl) begin
        if (run_rise)                         load_pend <= 1'b1;
        else if (!f_run(wdata[CTRL_W-1:0]))   load_pend <= 1'b0;
      end else if (load_done) begin
        load_pend <= 1'b0;
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL:   rdata[CTRL_W-1:0] = ctrl_q;
      A_RELOAD: rdata[CW-1:0]     = reload_q;
      A_COUNT:  rdata[CW-1:0]     = load_pend ? '0 : cap_count;
      default:  rdata[0]          = status_q;
    endcase
  end

  assign ctl_o.en      = ctrl_q[B_EN];
  assign ctl_o.run     = ctrl_q[B_START];
  assign ctl_o.halt_en = ctrl_q[B_HALT];
  assign reload_o      = reload_q;
  assign irq           = status_q;

  p_w1c_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && wdata[0] && !exp_evt) |=> !irq);

  p_status_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q && !we) |=> irq);

  p_ctrl_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !wdata[B_EN]) |=> !irq);

endmodule

// File: rtl/slow_tick_timer.sv
module slow_tick_timer #(
  parameter int CW          = 28,
  parameter int DW          = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic          bus_clk,
  input  logic          slow_clk,
  input  logic          rst_n,
  input  logic [1:0]    reg_addr,
  input  logic          reg_we,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          dbg_halt,
  output logic          irq
);
  import tt_pkg::*;

  localparam int XW = $bits(tt_ctl_t) + 1;

  tt_ctl_t         ctl_bus;
  tt_ctl_t         ctl_slow;
  logic [CW-1:0]   reload_bus;
  logic [XW-1:0]   to_slow_q;
  logic            halt_slow;
  logic [CW-1:0]   count_slow;
  logic            load_tgl, exp_tgl, pub_tgl, pub_bus;

  tt_bus_regs #(.CW(CW), .DW(DW)) u_regs (
    .clk        (bus_clk),
    .rst_n      (rst_n),
    .addr       (reg_addr),
    .we         (reg_we),
    .wdata      (reg_wdata),
    .rdata      (reg_rdata),
    .ctl_o      (ctl_bus),
    .reload_o   (reload_bus),
    .pub_s      (pub_bus),
    .snap_count (count_slow),
    .snap_load  (load_tgl),
    .snap_exp   (exp_tgl),
    .irq        (irq)
  );

  tt_sync #(.W(XW), .STAGES(SYNC_STAGES)) u_to_slow (
    .clk   (slow_clk),
    .rst_n (rst_n),
    .d     ({dbg_halt, ctl_bus}),
    .q     (to_slow_q)
  );

  assign halt_slow = to_slow_q[XW-1];
  assign ctl_slow  = tt_ctl_t'(to_slow_q[XW-2:0]);

  tt_slow_core #(.CW(CW)) u_core (
    .clk      (slow_clk),
    .rst_n    (rst_n),
    .ctl_s    (ctl_slow),
    .halt_s   (halt_slow),
    .reload   (reload_bus),
    .count    (count_slow),
    .load_tgl (load_tgl),
    .exp_tgl  (exp_tgl),
    .pub_tgl  (pub_tgl)
  );

  tt_sync #(.W(1), .STAGES(SYNC_STAGES)) u_to_bus (
    .clk   (bus_clk),
    .rst_n (rst_n),
    .d     (pub_tgl),
    .q     (pub_bus)
  );

endmodule

// File: tb/tb_slow_tick_timer.sv
`timescale 1ns/1ps
module tb_slow_tick_timer;

  logic        bus_clk = 1'b0;
  logic        slow_clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        dbg_halt = 1'b0;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;

  always #2  bus_clk  = ~bus_clk;
  always #51 slow_clk = ~slow_clk;

  slow_tick_timer dut (
    .bus_clk(bus_clk), .slow_clk(slow_clk), .rst_n(rst_n),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .dbg_halt(dbg_halt), .irq(irq)
  );

  localparam logic [31:0] VP [7] = '{32'd10, 32'd10, 32'd10, 32'd10, 32'd7,
                                     32'hF000_0005, 32'h0FFF_FFFF};
  localparam int          VK [7] = '{0, 3, 9, 10, 15, 1, 2};

  function automatic logic [31:0] model_count(input logic [31:0] pl, input int k);
    logic [31:0] p;
    p = pl & 32'h0FFF_FFFF;
    if (p == 0) return 32'd0;
    return p - (32'(k) % p);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge bus_clk); reg_addr = a; reg_we = 1'b1; reg_wdata = d;
    @(negedge bus_clk); reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge bus_clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic slow_ticks(input int n);
    repeat (n) @(posedge slow_clk);
    repeat (5) @(posedge bus_clk);
  endtask

  task automatic start_timer(input logic [31:0] pl, input logic [31:0] ctl);
    bus_write(2'd0, 32'd0);
    repeat (4) @(posedge slow_clk);
    bus_write(2'd1, pl);
    @(posedge slow_clk);
    bus_write(2'd0, ctl);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge bus_clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] v, v1, v2;
    repeat (5) @(negedge bus_clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int a = 0; a < 4; a++) begin
      bus_read(2'(a), v);
      check("R1 reset register", v, 32'd0);
    end
    check("R1 reset irq", {31'd0, irq}, 32'd0);

    // R3 R4 R2: vector table walk
    for (int i = 0; i < 7; i++) begin
      start_timer(VP[i], 32'd3);
      slow_ticks(3 + VK[i]);
      bus_read(2'd2, v);
      check("R3/R4 count vector", v, model_count(VP[i], VK[i]));
      if (VP[i][31:28] != 4'h0) begin
        bus_read(2'd1, v);
        check("R2 reload masked", v, VP[i] & 32'h0FFF_FFFF);
      end
    end

    // R6 R2 R3 R5
    start_timer(32'd30, 32'd3);
    slow_ticks(3 + 4);
    bus_read(2'd2, v);
    check("R4 running count", v, 32'd26);
    bus_write(2'd0, 32'd1);
    slow_ticks(4);
    bus_read(2'd2, v1);
    bus_write(2'd2, 32'h0000_0055);
    bus_read(2'd2, v);
    check("R2 count write ignored", v, v1);
    check("R2 held count nonzero", {31'd0, v1 != 0}, 32'd1);
    bus_write(2'd1, 32'd40);
    @(posedge slow_clk);
    bus_write(2'd0, 32'd3);
    bus_read(2'd2, v);
    check("R6 count zero while load pending", v, 32'd0);
    bus_read(2'd0, v);
    check("R6 start reads set", v, 32'd3);
    slow_ticks(3);
    bus_read(2'd2, v);
    check("R3 loaded after three slow edges", v, 32'd40);
    bus_write(2'd1, 32'd5);
    slow_ticks(5);
    bus_read(2'd2, v);
    check("R5 current count undisturbed", v, 32'd35);
    slow_ticks(35);
    bus_read(2'd2, v);
    check("R5 new reload used at expiry", v, 32'd5);
    slow_ticks(1);
    bus_read(2'd2, v);
    check("R5 counts from new reload", v, 32'd4);

    // R7 R8
    start_timer(32'd3, 32'd3);
    slow_ticks(3 + 1);
    check("R7 no irq before expiry", {31'd0, irq}, 32'd0);
    slow_ticks(2);
    bus_read(2'd3, v);
    check("R7 status set at expiry", v, 32'd1);
    check("R7 irq follows status", {31'd0, irq}, 32'd1);
    bus_write(2'd3, 32'd1);
    bus_read(2'd3, v);
    check("R7 write-one clears status", v, 32'd0);
    check("R7 irq low after clear", {31'd0, irq}, 32'd0);
    slow_ticks(3);
    check("R7 irq again next period", {31'd0, irq}, 32'd1);
    bus_write(2'd0, 32'd0);
    check("R8 control zero drops irq", {31'd0, irq}, 32'd0);
    bus_read(2'd3, v);
    check("R8 control zero clears status", v, 32'd0);
    slow_ticks(4);
    bus_read(2'd2, v);
    check("R8 disabled count zero", v, 32'd0);

    // R9
    start_timer(32'd100, 32'd7);
    slow_ticks(3 + 5);
    bus_read(2'd2, v);
    check("R9 counting before halt", v, 32'd95);
    dbg_halt = 1'b1;
    slow_ticks(6);
    bus_read(2'd2, v1);
    check("R9 frozen value", v1, 32'd93);
    slow_ticks(4);
    bus_read(2'd2, v2);
    check("R9 stays frozen", v2, v1);
    bus_write(2'd0, 32'd3);
    slow_ticks(6);
    bus_read(2'd2, v);
    n_chk++;
    if (!(v < v1)) begin
      n_fail++;
      $display("FAIL R9 halt ignored without halt-enable: actual=%h expected below %h", v, v1);
    end
    dbg_halt = 1'b0;

    finish_run();
  end

endmodule